// File: doc/BRIEF.md
# Vector Register Gather Engine

The engine performs an indexed permutation over groups of vector registers. A start pulse supplies the element width, the group multiplier, the vector length, a mask-enable flag, the index mode and three base register numbers: destination, index and source. The engine then walks positions `i = 0 .. vl-1`, one per clock. At each position it reads an unsigned index from the index group and writes the source element at that index into destination element `i`. If the index is not below the group's element capacity (VLMAX), it writes zero instead.

Two index modes exist. In same-width mode the index elements have the data element width. In 16-bit mode every index is a 16-bit value, whatever the data width is. The register file sits inside the block as a small array. A plain write port lets the surrounding logic load it and a combinational read port lets it inspect it. The engine's own writes take priority over the load port.

Top module: `gather_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both low.
- R2: For an active position `i` whose index `k` is below VLMAX, destination element `i` receives source element `k`. Element `j` of a group with width `w` bytes occupies bytes `j*w .. j*w+w-1`, counted little-endian from byte 0 of the base register, and continuing into the next register numbers, 8 bytes per register.
- R3: An index equal to or above VLMAX writes zero. The index is compared unsigned in its full width, so 16-bit values such as 0x0107 or 0xFFFF never wrap into range when the data width is 8 bits.
- R4: VLMAX equals 64 * LMUL / SEW. `cfg_lmul` is a signed 3-bit log2 of LMUL (values -3..3, so fractional multipliers are allowed). `cfg_sew` codes the width: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R5: With `cfg_ei16` = 0, index elements have the data width and use the R2 layout in the index group.
- R6: With `cfg_ei16` = 1, index elements are 16 bits wide and use the R2 layout with w = 2 for every data width.
- R7: With `cfg_masked` = 1, a position whose bit `i` of register 0 is clear is skipped, and its destination element keeps its old value.
- R8: No destination element at position `vl` or above is written. With `vl` = 0, nothing is written.
- R9: One element is handled per clock. `done` is high for exactly one cycle, `vl+1` clocks after the clock edge that samples `start`.
- R10: A `start` pulse, or a configuration change, while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the cfg_* values |
| cfg_sew | input | 2 | Data element width code |
| cfg_lmul | input | 3 | Signed log2 of the group multiplier |
| cfg_vl | input | 7 | Number of positions to process |
| cfg_masked | input | 1 | Honour mask bits in register 0 |
| cfg_ei16 | input | 1 | Use 16-bit indices |
| cfg_vd | input | 5 | Destination group base register |
| cfg_vs1 | input | 5 | Index group base register |
| cfg_vs2 | input | 5 | Source group base register |
| rf_we | input | 1 | Load-port write enable (honoured while idle) |
| rf_waddr | input | 5 | Load-port register number |
| rf_wdata | input | 64 | Load-port data |
| rf_raddr | input | 5 | Inspection read register number |
| rf_rdata | output | 64 | Inspection read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sets indices exactly at VLMAX, just below it, and at 16-bit values whose low byte lies in range. A design that truncates the index to the data width would copy a real element where zero belongs. Fractional multipliers shrink VLMAX to a single element, which exposes a shift taken in the wrong direction. The bench also runs tails with `vl` below VLMAX and with `vl` = 0 to catch stray writes past the last position. Sparse mask patterns catch a skipped element that gets zeroed instead of kept. A second start pulse mid-run with a different configuration would stretch or corrupt the run if it were latched. Every data width is tried in both index modes, so index and data lane offsets that share one stride would misplace elements.

// File: rtl/gather_pkg.sv
package gather_pkg;
    parameter int VLEN = 64;
    parameter int NREG = 32;
    localparam int RA_W  = $clog2(NREG);
    localparam int VLB   = VLEN / 8;
    localparam int OFF_W = $clog2(VLB);
    localparam int CNT_W = $clog2(VLEN) + 1;

    typedef enum logic [1:0] {SEW8 = 2'd0, SEW16 = 2'd1, SEW32 = 2'd2, SEW64 = 2'd3} sew_e;

    typedef struct packed {
        sew_e               sew;
        logic signed [2:0]  lmul;
        logic [CNT_W-1:0]   vl;
        logic               masked;
        logic               ei16;
        logic [RA_W-1:0]    vd;
        logic [RA_W-1:0]    vs1;
        logic [RA_W-1:0]    vs2;
    } gcfg_t;

    typedef struct packed {
        logic [RA_W-1:0]  rnum;
        logic [OFF_W-1:0] off;
    } eloc_t;

    // element capacity of a group: VLEN scaled by LMUL/SEW
    function automatic logic [CNT_W-1:0] vlmax_of(sew_e s, logic signed [2:0] lm);
        int sh;
        sh = int'(lm) - int'(s) - 3;
        if (sh < 0) return CNT_W'(VLEN >> (-sh));
        else        return CNT_W'(VLEN << sh);
    endfunction

    // register number and byte offset of element idx of size 2^szl bytes
    function automatic eloc_t locate(logic [RA_W-1:0] base, logic [CNT_W-1:0] idx,
                                     logic [1:0] szl);
        logic [CNT_W+2:0] ba;
        eloc_t r;
        ba     = {3'b000, idx} << szl;
        r.rnum = base + RA_W'(ba >> OFF_W);
        r.off  = ba[OFF_W-1:0];
        return r;
    endfunction

    function automatic logic [63:0] size_mask(logic [1:0] szl);
        case (szl)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] pick(logic [VLEN-1:0] w, logic [OFF_W-1:0] off,
                                         logic [1:0] szl);
        logic [VLEN-1:0] sh;
        sh = w >> {off, 3'b000};
        return sh[63:0] & size_mask(szl);
    endfunction

    function automatic logic [VLEN-1:0] merge(logic [VLEN-1:0] w, logic [OFF_W-1:0] off,
                                              logic [1:0] szl, logic [63:0] val);
        logic [VLEN-1:0] m, v;
        m = VLEN'(size_mask(szl)) << {off, 3'b000};
        v = VLEN'(val & size_mask(szl)) << {off, 3'b000};
        return (w & ~m) | v;
    endfunction
endpackage

// File: rtl/gather_rf.sv
module gather_rf import gather_pkg::*; #(
    parameter int NRD = 2
) (
    input  logic                clk,
    input  logic                we,
    input  logic [RA_W-1:0]     waddr,
    input  logic [VLEN-1:0]     wdata,
    input  logic [NRD*RA_W-1:0] raddr,
    output logic [NRD*VLEN-1:0] rdata
);
    logic [VLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p*VLEN +: VLEN] = mem[raddr[p*RA_W +: RA_W]];
    end
endmodule

// File: rtl/gather_ctrl.sv
module gather_ctrl import gather_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  gcfg_t            cfg_in,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt,
    output gcfg_t            cfg_q
);
    typedef enum logic {ST_IDLE, ST_RUN} st_e;
    st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            done  <= 1'b0;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cfg_q <= cfg_in;
                    cnt   <= '0;
                    if (cfg_in.vl == '0) done <= 1'b1;
                    else                 st   <= ST_RUN;
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == cfg_q.vl - 1'b1) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (st == ST_RUN);
endmodule

// File: rtl/gather_lane.sv
module gather_lane import gather_pkg::*; (
    input  logic             run,
    input  gcfg_t            cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [VLEN-1:0]  idx_word,
    input  logic [VLEN-1:0]  src_word,
    input  logic [VLEN-1:0]  v0_word,
    input  logic [VLEN-1:0]  dst_word,
    output logic [RA_W-1:0]  idx_reg,
    output logic [RA_W-1:0]  src_reg,
    output logic [RA_W-1:0]  dst_reg,
    output logic             we,
    output logic [VLEN-1:0]  wdata
);
    logic [1:0]       isz;
    eloc_t            il, sl, dl;
    logic [63:0]      idx_val, src_val;
    logic [CNT_W-1:0] vmax;
    logic             oor, mbit;

    // index lane size differs from data lane size in 16-bit mode
    assign isz     = cfg.ei16 ? 2'd1 : cfg.sew;
    assign vmax    = vlmax_of(cfg.sew, cfg.lmul);
    assign il      = locate(cfg.vs1, cnt, isz);
    assign idx_val = pick(idx_word, il.off, isz);
    assign oor     = idx_val >= 64'(vmax);
    assign sl      = locate(cfg.vs2, idx_val[CNT_W-1:0], cfg.sew);
    assign src_val = pick(src_word, sl.off, cfg.sew);
    assign dl      = locate(cfg.vd, cnt, cfg.sew);
    assign mbit    = |(v0_word & (VLEN'(1) << cnt));

    assign idx_reg = il.rnum;
    assign src_reg = sl.rnum;
    assign dst_reg = dl.rnum;
    assign we      = run && (!cfg.masked || mbit);
    assign wdata   = merge(dst_word, dl.off, cfg.sew, oor ? 64'd0 : src_val);
endmodule

// File: rtl/gather_engine.sv
module gather_engine import gather_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_sew,
    input  logic [2:0]        cfg_lmul,
    input  logic [CNT_W-1:0]  cfg_vl,
    input  logic              cfg_masked,
    input  logic              cfg_ei16,
    input  logic [RA_W-1:0]   cfg_vd,
    input  logic [RA_W-1:0]   cfg_vs1,
    input  logic [RA_W-1:0]   cfg_vs2,
    input  logic              rf_we,
    input  logic [RA_W-1:0]   rf_waddr,
    input  logic [VLEN-1:0]   rf_wdata,
    input  logic [RA_W-1:0]   rf_raddr,
    output logic [VLEN-1:0]   rf_rdata,
    output logic              busy,
    output logic              done
);
    localparam int NRD = 5; // inspect, index, source, mask, destination

    gcfg_t            cfg_in, cfg_q;
    logic [CNT_W-1:0] cnt;
    logic [RA_W-1:0]  idx_reg, src_reg, dst_reg;
    logic [VLEN-1:0]  rd_idx, rd_src, rd_v0, rd_dst, eng_wdata;
    logic             eng_we;
    logic [NRD*RA_W-1:0] raddr;
    logic [NRD*VLEN-1:0] rdata;

    assign cfg_in = '{sew: sew_e'(cfg_sew), lmul: cfg_lmul, vl: cfg_vl,
                      masked: cfg_masked, ei16: cfg_ei16,
                      vd: cfg_vd, vs1: cfg_vs1, vs2: cfg_vs2};

    gather_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in),
        .busy(busy), .done(done), .cnt(cnt), .cfg_q(cfg_q)
    );

    assign raddr = {dst_reg, RA_W'(0), src_reg, idx_reg, rf_raddr};
    assign rf_rdata = rdata[0*VLEN +: VLEN];
    assign rd_idx   = rdata[1*VLEN +: VLEN];
    assign rd_src   = rdata[2*VLEN +: VLEN];
    assign rd_v0    = rdata[3*VLEN +: VLEN];
    assign rd_dst   = rdata[4*VLEN +: VLEN];

    gather_lane u_lane (
        .run(busy), .cfg(cfg_q), .cnt(cnt),
        .idx_word(rd_idx), .src_word(rd_src), .v0_word(rd_v0), .dst_word(rd_dst),
        .idx_reg(idx_reg), .src_reg(src_reg), .dst_reg(dst_reg),
        .we(eng_we), .wdata(eng_wdata)
    );

    gather_rf #(.NRD(NRD)) u_rf (
        .clk(clk),
        .we(eng_we | (rf_we & ~busy)),
        .waddr(eng_we ? dst_reg : rf_waddr),
        .wdata(eng_we ? eng_wdata : rf_wdata),
        .raddr(raddr),
        .rdata(rdata)
    );
endmodule

// File: rtl/gather_chk.sv
module gather_chk import gather_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] vl_q,
    input logic             eng_we
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_ONE_PER_CLK: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || cnt == $past(cnt) + 1'b1)); // R9
    AST_RUN_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R10
    AST_WRITE_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> busy); // R8
    AST_POS_BELOW_VL: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt < vl_q); // R8
endmodule

bind gather_engine gather_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cnt(cnt), .vl_q(cfg_q.vl), .eng_we(eng_we)
);

// File: tb/sim_gather_engine.sv
module sim_gather_engine;
    import gather_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, start = 1'b0;
    logic [1:0] cfg_sew = '0;
    logic [2:0] cfg_lmul = '0;
    logic [CNT_W-1:0] cfg_vl = '0;
    logic cfg_masked = 1'b0, cfg_ei16 = 1'b0;
    logic [RA_W-1:0] cfg_vd = RA_W'(8), cfg_vs1 = RA_W'(16), cfg_vs2 = RA_W'(24);
    logic rf_we = 1'b0;
    logic [RA_W-1:0] rf_waddr = '0, rf_raddr = '0;
    logic [VLEN-1:0] rf_wdata = '0, rf_rdata;
    logic busy, done;

    gather_engine u0 (.*);

    int total = 0, bad = 0;
    logic [VLEN-1:0] bref [NREG];

    typedef struct packed {
        logic [1:0] sew; logic [2:0] lmul; logic [CNT_W-1:0] vl;
        logic msk; logic ei16; logic [CNT_W-1:0] vmax;
    } tv_t;

    // vmax column: hand-computed 64*LMUL/SEW (R4)
    localparam tv_t TV [12] = '{
        '{2'd0, 3'd0, 7'd8,  1'b0, 1'b0, 7'd8},
        '{2'd1, 3'd1, 7'd8,  1'b0, 1'b0, 7'd8},
        '{2'd2, 3'd2, 7'd8,  1'b1, 1'b0, 7'd8},
        '{2'd3, 3'd3, 7'd8,  1'b0, 1'b0, 7'd8},
        '{2'd0, 3'd7, 7'd4,  1'b0, 1'b0, 7'd4},
        '{2'd0, 3'd1, 7'd16, 1'b0, 1'b1, 7'd16},
        '{2'd1, 3'd0, 7'd4,  1'b1, 1'b1, 7'd4},
        '{2'd2, 3'd1, 7'd4,  1'b0, 1'b1, 7'd4},
        '{2'd3, 3'd2, 7'd4,  1'b1, 1'b1, 7'd4},
        '{2'd1, 3'd2, 7'd10, 1'b0, 1'b0, 7'd16},
        '{2'd1, 3'd6, 7'd1,  1'b0, 1'b1, 7'd1},
        '{2'd0, 3'd3, 7'd64, 1'b1, 1'b0, 7'd64}
    };

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] bget(int base, int i, int wb);
        logic [63:0] v = '0;
        for (int b = 0; b < wb; b++) begin
            int a = i * wb + b;
            v[8*b +: 8] = bref[base + a / VLB][8*(a % VLB) +: 8];
        end
        return v;
    endfunction

    task automatic bput(int base, int i, int wb, logic [63:0] val);
        for (int b = 0; b < wb; b++) begin
            int a = i * wb + b;
            bref[base + a / VLB][8*(a % VLB) +: 8] = val[8*b +: 8];
        end
    endtask

    task automatic fill(int seed);
        for (int r = 0; r < NREG; r++)
            for (int b = 0; b < VLB; b++)
                bref[r][8*b +: 8] = 8'(r * 37 + b * 11 + seed * 13 + 5);
        bref[0] = 64'hA5C3_5A3C_F00F_9669 ^ {8{8'(seed)}};
    endtask

    task automatic load_idx(int iw, int vmax, int n, int seed);
        for (int k = 0; k < n; k++) begin
            logic [63:0] v;
            if (k % 7 == 6) v = (iw == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*iw)) - 1);
            else v = 64'((k * 5 + seed) % (vmax + 4));
            bput(16, k, iw, v);
        end
    endtask

    task automatic push_all();
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            rf_we = 1'b1; rf_waddr = RA_W'(r); rf_wdata = bref[r];
        end
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic model(int sew, int vl, bit msk, bit ei16, int vmax);
        int dw = 1 << sew;
        int iw = ei16 ? 2 : dw;
        for (int i = 0; i < vl; i++) begin
            logic [63:0] idx, val;
            if (msk && !bref[0][i]) continue;
            idx = bget(16, i, iw);
            val = (idx >= 64'(vmax)) ? 64'd0 : bget(24, int'(idx), dw);
            bput(8, i, dw, val);
        end
    endtask

    task automatic run_op(logic [1:0] s, logic [2:0] l, int vl, bit m, bit e, output int cyc);
        @(negedge clk);
        cfg_sew = s; cfg_lmul = l; cfg_vl = CNT_W'(vl); cfg_masked = m; cfg_ei16 = e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic cmp_all(string req);
        for (int r = 0; r < NREG; r++) begin
            rf_raddr = RA_W'(r);
            #1;
            chk(rf_rdata === bref[r], $sformatf("%s reg%0d", req, r), rf_rdata, bref[r]);
        end
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk(done === 1'b0, "R1 done after reset", 64'(done), 64'd0);

        // table walk: R2 R4 R5 R6 R7 R8 R9
        foreach (TV[t]) begin
            int dw = 1 << TV[t].sew;
            fill(t + 1);
            load_idx(TV[t].ei16 ? 2 : dw, int'(TV[t].vmax), int'(TV[t].vl), t);
            push_all();
            model(int'(TV[t].sew), int'(TV[t].vl), TV[t].msk, TV[t].ei16, int'(TV[t].vmax));
            run_op(TV[t].sew, TV[t].lmul, int'(TV[t].vl), TV[t].msk, TV[t].ei16, cyc);
            chk(cyc == int'(TV[t].vl) + 1, $sformatf("R9 latency case%0d", t),
                64'(cyc), 64'(int'(TV[t].vl) + 1));
            @(negedge clk);
            chk(done === 1'b0, $sformatf("R9 done width case%0d", t), 64'(done), 64'd0);
            cmp_all($sformatf("R2/R5/R6/R7/R8 case%0d", t));
        end

        // R3: boundary and wide 16-bit indices with 8-bit data
        begin
            logic [63:0] exp8;
            fill(99);
            bput(16, 0, 2, 64'hFFFF);
            bput(16, 1, 2, 64'h0107);
            bput(16, 2, 2, 64'd8);
            bput(16, 3, 2, 64'd7);
            push_all();
            exp8 = {bref[8][63:32], bref[24][63:56], 24'd0};
            run_op(2'd0, 3'd0, 4, 1'b0, 1'b1, cyc);
            rf_raddr = RA_W'(8);
            #1;
            chk(rf_rdata === exp8, "R3 out-of-range indices", rf_rdata, exp8);
        end

        // R8: zero length writes nothing and completes next cycle
        fill(55);
        load_idx(1, 8, 8, 3);
        push_all();
        run_op(2'd0, 3'd0, 0, 1'b0, 1'b0, cyc);
        chk(cyc == 1, "R8 vl=0 latency", 64'(cyc), 64'd1);
        cmp_all("R8 vl=0 untouched");

        // R10: second start and configuration change mid-run are ignored
        fill(77);
        load_idx(1, 16, 16, 2);
        push_all();
        model(0, 16, 1'b0, 1'b0, 16);
        @(negedge clk);
        cfg_sew = 2'd0; cfg_lmul = 3'd1; cfg_vl = CNT_W'(16); cfg_masked = 1'b0; cfg_ei16 = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (3) begin @(negedge clk); cyc++; end
        cfg_sew = 2'd3; cfg_vl = CNT_W'(2); cfg_vd = RA_W'(4); start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0; cfg_vd = RA_W'(8);
        while (!done && cyc < 300) begin @(negedge clk); cyc++; end
        chk(cyc == 17, "R10 restart ignored latency", 64'(cyc), 64'd17);
        cmp_all("R10 restart ignored result");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule